// File: doc/BRIEF.md
# ASID Ring-Matched Translation Lookaside Buffer

This block translates 32-bit virtual addresses through a small set-associative translation buffer and checks access rights in the same step. Every way holds, for each of its index slots, a virtual page number, a physical page number, an 8-bit address-space tag and a 4-bit attribute. A 32-bit ring map register holds four tags, one per byte. An entry's ring is the number of the byte whose tag matches the entry's tag. Tag value zero marks a slot as empty.

A request gives a virtual address, an access kind and the privilege level of the requester. One cycle later the block returns either a physical address with its rights and cache mode, or a fault cause. Possible faults are miss, multiple hit, privilege violation and prohibited access, and instruction fetches use a different set of cause codes from loads and stores. With each response the block also reports the address of the page-table word that would map the request, so an external walker can fetch that word. The walker hands the fetched word back through the refill port, and the block places it in the next way in round-robin order. A plain write port loads a chosen way directly.

Top module: `asid_ring_tlb`

## Requirements
- R1: A way hits when its stored page number equals vaddr[31:12], its tag is nonzero, and the tag equals one of the four bytes of the ring map. The ring is the index of the matching byte. When several bytes match, the lowest-numbered byte wins.
- R2: When two or more ways hit, the cause is 17 for a fetch and 25 for a load or store.
- R3: When no way hits, the cause is 16 for a fetch and 24 for a load or store. A tag of zero, or a tag that is in no byte of the ring map, never hits.
- R4: After reset the ring map is 0x04030201, the refill counter is 0, and every slot is empty.
- R5: On a single hit whose ring is numerically below req_priv_i, the cause is 18 for a fetch and 26 otherwise.
- R6: Attribute decode. For values 0 to 11: read is always granted, bit 0 grants execute, bit 1 grants write, and the cache mode is bits [3:2] (0 bypass, 1 write-back, 2 write-through). Value 13 grants read and write with cache mode 3 (isolate). Every other value grants nothing. rsp_rights_o is {execute, write, read}.
- R7: Access kinds are req_kind_i 2 = fetch, 1 = store, and 0 or 3 = load. A fetch has read and write masked off. A load or store has execute masked off. A denied fetch gives cause 20, a denied store gives 29 and a denied load gives 28. On any fault, rights, cache mode and physical address read zero.
- R8: On success (cause 0), the physical address is the hit entry's physical page number in bits [31:12] and vaddr[11:0] in bits [11:0].
- R9: A refill first increments the 2-bit refill counter and then writes way = new counter value, at slot vpn[1:0]. The written entry takes its physical page from pte[31:12], its attribute from pte[3:0], and its tag from the ring-map byte selected by pte[5:4].
- R10: pte_addr_o = (ptbase_i | (vaddr >> 10)) with bits [1:0] cleared. It is registered together with each response.
- R11: The response is valid exactly in the cycle after req_valid_i. A write, refill or ring-map update made in the same cycle as a request does not affect that request. It is seen by the next request.
- R12: The write port stores page number, physical page, tag and attribute into way wr_way_i, at slot wr_vpn_i[1:0]. When a refill targets the same way in the same cycle, the refill takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rasid_we_i | input | 1 | Load the ring map |
| rasid_i | input | 32 | New ring map, byte n is the tag of ring n |
| wr_en_i | input | 1 | Direct entry write |
| wr_way_i | input | 2 | Way written by the write port |
| wr_vpn_i | input | 20 | Virtual page number; bits [1:0] select the slot |
| wr_ppn_i | input | 20 | Physical page number |
| wr_asid_i | input | 8 | Address-space tag, 0 = empty |
| wr_attr_i | input | 4 | Attribute |
| refill_en_i | input | 1 | Refill from a fetched page-table word |
| refill_vpn_i | input | 20 | Virtual page number of the refilled mapping |
| refill_pte_i | input | 32 | Page-table word |
| ptbase_i | input | 32 | Page-table base address |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0/3 load, 1 store, 2 fetch |
| req_priv_i | input | 2 | Requester privilege level |
| rsp_valid_o | output | 1 | Response valid |
| rsp_cause_o | output | 6 | 0 on success, otherwise fault cause |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_rights_o | output | 3 | {execute, write, read} after masking |
| rsp_cache_o | output | 2 | Cache mode |
| rsp_ring_o | output | 2 | Ring of the hit entry |
| pte_addr_o | output | 32 | Address of the page-table word for the request |

## Verification
A refill or direct write can land in the same cycle as a lookup of the same page. The bench provokes this by raising refill_en_i and req_valid_i on one edge, for a page whose slot is empty. The response must still report a miss, and a lookup on the next cycle must hit with the refilled physical page. The bench also drives a refill and a direct write to the same way and slot together, and only the refilled contents may remain visible. Every expected value comes from an arithmetic model in the bench, which is updated only after the response it predicts.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam logic [5:0] CAUSE_OK        = 6'd0;
  localparam logic [5:0] CAUSE_I_MISS    = 6'd16;
  localparam logic [5:0] CAUSE_I_MULTI   = 6'd17;
  localparam logic [5:0] CAUSE_I_PRIV    = 6'd18;
  localparam logic [5:0] CAUSE_I_PROHIB  = 6'd20;
  localparam logic [5:0] CAUSE_D_MISS    = 6'd24;
  localparam logic [5:0] CAUSE_D_MULTI   = 6'd25;
  localparam logic [5:0] CAUSE_D_PRIV    = 6'd26;
  localparam logic [5:0] CAUSE_LD_PROHIB = 6'd28;
  localparam logic [5:0] CAUSE_ST_PROHIB = 6'd29;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] CACHE_ISOLATE = 2'd3;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ATTR_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [$clog2(ENTRIES)-1:0] widx_i,
  input  logic [VPN_W-1:0]           wvpn_i,
  input  logic [VPN_W-1:0]           wppn_i,
  input  logic [ASID_W-1:0]          wasid_i,
  input  logic [ATTR_W-1:0]          wattr_i,
  input  logic [$clog2(ENTRIES)-1:0] ridx_i,
  output logic [VPN_W-1:0]           rvpn_o,
  output logic [VPN_W-1:0]           rppn_o,
  output logic [ASID_W-1:0]          rasid_o,
  output logic [ATTR_W-1:0]          rattr_o
);
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [VPN_W-1:0]  ppn_q  [ENTRIES];
  logic [ASID_W-1:0] asid_q [ENTRIES];
  logic [ATTR_W-1:0] attr_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        vpn_q[e]  <= '0;
        ppn_q[e]  <= '0;
        asid_q[e] <= '0;
        attr_q[e] <= '0;
      end
    end else if (we_i) begin
      vpn_q[widx_i]  <= wvpn_i;
      ppn_q[widx_i]  <= wppn_i;
      asid_q[widx_i] <= wasid_i;
      attr_q[widx_i] <= wattr_i;
    end
  end

  assign rvpn_o  = vpn_q[ridx_i];
  assign rppn_o  = ppn_q[ridx_i];
  assign rasid_o = asid_q[ridx_i];
  assign rattr_o = attr_q[ridx_i];
endmodule

// File: rtl/tlb_ring_match.sv
module tlb_ring_match #(
  parameter int ASID_W = 8,
  parameter int RINGS  = 4
) (
  input  logic [ASID_W-1:0]       asid_i,
  input  logic [RINGS*ASID_W-1:0] rasid_i,
  output logic                    match_o,
  output logic [$clog2(RINGS)-1:0] ring_o
);
  localparam int RING_W = $clog2(RINGS);

  // scan high to low so the lowest matching byte wins
  always_comb begin
    match_o = 1'b0;
    ring_o  = '0;
    for (int i = RINGS - 1; i >= 0; i--) begin
      if (rasid_i[i*ASID_W +: ASID_W] == asid_i) begin
        match_o = 1'b1;
        ring_o  = RING_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_rights_decode.sv
module tlb_rights_decode
  import asid_tlb_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [1:0]        kind_i,
  output logic [2:0]        rights_o,
  output logic [1:0]        cache_o,
  output logic              granted_o
);
  logic rd, wr, ex;

  always_comb begin
    rd      = 1'b0;
    wr      = 1'b0;
    ex      = 1'b0;
    cache_o = 2'd0;
    if (attr_i < ATTR_W'(12)) begin
      rd      = 1'b1;
      ex      = attr_i[0];
      wr      = attr_i[1];
      cache_o = attr_i[3:2];
    end else if (attr_i == ATTR_W'(13)) begin
      rd      = 1'b1;
      wr      = 1'b1;
      cache_o = CACHE_ISOLATE;
    end
    if (kind_i == KIND_FETCH) begin
      rd = 1'b0;
      wr = 1'b0;
    end else begin
      ex = 1'b0;
    end
  end

  assign rights_o  = {ex, wr, rd};
  assign granted_o = (kind_i == KIND_FETCH) ? ex :
                     (kind_i == KIND_STORE) ? wr : rd;
endmodule

// File: rtl/asid_ring_tlb.sv
module asid_ring_tlb
  import asid_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_WAYS  = 4,
  parameter int ENTRIES   = 4,
  parameter int ASID_W    = 8,
  parameter int ATTR_W    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rasid_we_i,
  input  logic [4*ASID_W-1:0]          rasid_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM_WAYS)-1:0]  wr_way_i,
  input  logic [VA_W-PAGE_BITS-1:0]    wr_vpn_i,
  input  logic [VA_W-PAGE_BITS-1:0]    wr_ppn_i,
  input  logic [ASID_W-1:0]            wr_asid_i,
  input  logic [ATTR_W-1:0]            wr_attr_i,
  input  logic                         refill_en_i,
  input  logic [VA_W-PAGE_BITS-1:0]    refill_vpn_i,
  input  logic [VA_W-1:0]              refill_pte_i,
  input  logic [VA_W-1:0]              ptbase_i,
  input  logic                         req_valid_i,
  input  logic [VA_W-1:0]              req_vaddr_i,
  input  logic [1:0]                   req_kind_i,
  input  logic [1:0]                   req_priv_i,
  output logic                         rsp_valid_o,
  output logic [5:0]                   rsp_cause_o,
  output logic [VA_W-1:0]              rsp_paddr_o,
  output logic [2:0]                   rsp_rights_o,
  output logic [1:0]                   rsp_cache_o,
  output logic [1:0]                   rsp_ring_o,
  output logic [VA_W-1:0]              pte_addr_o
);
  localparam int VPN_W   = VA_W - PAGE_BITS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int WAY_W   = $clog2(NUM_WAYS);
  localparam int RINGS   = 4;
  localparam int RING_W  = $clog2(RINGS);
  localparam int RASID_W = RINGS * ASID_W;
  localparam int CNT_W   = $clog2(NUM_WAYS + 1);

  function automatic logic [RASID_W-1:0] rasid_reset();
    logic [RASID_W-1:0] r;
    for (int i = 0; i < RINGS; i++) r[i*ASID_W +: ASID_W] = ASID_W'(i + 1);
    return r;
  endfunction

  logic [RASID_W-1:0] rasid_q;
  logic [WAY_W-1:0]   ridx_q;
  logic [WAY_W-1:0]   refill_way;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rasid_q <= rasid_reset();
      ridx_q  <= '0;
    end else begin
      if (rasid_we_i) rasid_q <= rasid_i;
      if (refill_en_i) ridx_q <= refill_way;
    end
  end

  assign refill_way = ridx_q + WAY_W'(1);

  // refill entry fields taken from the page-table word
  logic [RING_W-1:0] pte_ring;
  logic [ASID_W-1:0] pte_asid;
  logic [VPN_W-1:0]  pte_ppn;
  logic [ATTR_W-1:0] pte_attr;
  logic              unused_pte;

  assign pte_ring   = refill_pte_i[5:4];
  assign pte_asid   = rasid_q[pte_ring*ASID_W +: ASID_W];
  assign pte_ppn    = refill_pte_i[VA_W-1:PAGE_BITS];
  assign pte_attr   = refill_pte_i[ATTR_W-1:0];
  assign unused_pte = ^refill_pte_i[PAGE_BITS-1:6];

  logic [VPN_W-1:0]  way_vpn   [NUM_WAYS];
  logic [VPN_W-1:0]  way_ppn   [NUM_WAYS];
  logic [ASID_W-1:0] way_asid  [NUM_WAYS];
  logic [ATTR_W-1:0] way_attr  [NUM_WAYS];
  logic [RING_W-1:0] way_ring  [NUM_WAYS];
  logic [NUM_WAYS-1:0] way_match, way_hit;
  logic [IDX_W-1:0]  req_idx;
  logic [VPN_W-1:0]  req_vpn;

  assign req_vpn = req_vaddr_i[VA_W-1:PAGE_BITS];
  assign req_idx = req_vaddr_i[PAGE_BITS +: IDX_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic rf_sel, wp_sel;
    assign rf_sel = refill_en_i && (refill_way == WAY_W'(w));
    assign wp_sel = wr_en_i && (wr_way_i == WAY_W'(w));

    tlb_way_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .ATTR_W(ATTR_W)
    ) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (rf_sel || wp_sel),
      .widx_i (rf_sel ? refill_vpn_i[IDX_W-1:0] : wr_vpn_i[IDX_W-1:0]),
      .wvpn_i (rf_sel ? refill_vpn_i : wr_vpn_i),
      .wppn_i (rf_sel ? pte_ppn : wr_ppn_i),
      .wasid_i(rf_sel ? pte_asid : wr_asid_i),
      .wattr_i(rf_sel ? pte_attr : wr_attr_i),
      .ridx_i (req_idx),
      .rvpn_o (way_vpn[w]),
      .rppn_o (way_ppn[w]),
      .rasid_o(way_asid[w]),
      .rattr_o(way_attr[w])
    );

    tlb_ring_match #(.ASID_W(ASID_W), .RINGS(RINGS)) u_ring (
      .asid_i (way_asid[w]),
      .rasid_i(rasid_q),
      .match_o(way_match[w]),
      .ring_o (way_ring[w])
    );

    assign way_hit[w] = (way_vpn[w] == req_vpn) && (way_asid[w] != '0) && way_match[w];
  end

  logic [CNT_W-1:0]  hit_cnt;
  logic [VPN_W-1:0]  sel_ppn;
  logic [ATTR_W-1:0] sel_attr;
  logic [RING_W-1:0] sel_ring;

  always_comb begin
    hit_cnt  = '0;
    sel_ppn  = '0;
    sel_attr = '0;
    sel_ring = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_hit[w]) begin
        hit_cnt  = hit_cnt + CNT_W'(1);
        sel_ppn  = way_ppn[w];
        sel_attr = way_attr[w];
        sel_ring = way_ring[w];
      end
    end
  end

  logic [2:0] dec_rights;
  logic [1:0] dec_cache;
  logic       dec_granted;

  tlb_rights_decode #(.ATTR_W(ATTR_W)) u_dec (
    .attr_i   (sel_attr),
    .kind_i   (req_kind_i),
    .rights_o (dec_rights),
    .cache_o  (dec_cache),
    .granted_o(dec_granted)
  );

  logic       is_fetch, is_store;
  logic [5:0] cause_d;

  assign is_fetch = (req_kind_i == KIND_FETCH);
  assign is_store = (req_kind_i == KIND_STORE);

  // fault priority: miss, multi-hit, privilege, rights
  always_comb begin
    if (hit_cnt == '0)               cause_d = is_fetch ? CAUSE_I_MISS  : CAUSE_D_MISS;
    else if (hit_cnt > CNT_W'(1))    cause_d = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
    else if (sel_ring < req_priv_i)  cause_d = is_fetch ? CAUSE_I_PRIV  : CAUSE_D_PRIV;
    else if (!dec_granted)           cause_d = is_fetch ? CAUSE_I_PROHIB :
                                               is_store ? CAUSE_ST_PROHIB : CAUSE_LD_PROHIB;
    else                             cause_d = CAUSE_OK;
  end

  logic ok_d;
  assign ok_d = (cause_d == CAUSE_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_cause_o  <= '0;
      rsp_paddr_o  <= '0;
      rsp_rights_o <= '0;
      rsp_cache_o  <= '0;
      rsp_ring_o   <= '0;
      pte_addr_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_cause_o  <= cause_d;
        rsp_paddr_o  <= ok_d ? {sel_ppn, req_vaddr_i[PAGE_BITS-1:0]} : '0;
        rsp_rights_o <= ok_d ? dec_rights : '0;
        rsp_cache_o  <= ok_d ? dec_cache : '0;
        rsp_ring_o   <= (hit_cnt == CNT_W'(1)) ? sel_ring : '0;
        pte_addr_o   <= (ptbase_i | (req_vaddr_i >> 10)) & ~VA_W'(3);
      end
    end
  end
endmodule

// File: rtl/asid_tlb_checker.sv
module asid_tlb_checker #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int WAY_W     = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic [1:0]       req_kind_i,
  input logic             refill_en_i,
  input logic [WAY_W-1:0] ridx_q,
  input logic             rsp_valid_o,
  input logic [5:0]       rsp_cause_o,
  input logic [VA_W-1:0]  rsp_paddr_o,
  input logic [2:0]       rsp_rights_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R11
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R11
  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_cause_o inside {6'd0, 6'd16, 6'd17, 6'd18, 6'd20,
                                        6'd24, 6'd25, 6'd26, 6'd28, 6'd29}); // R5
  AST_OK_HAS_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cause_o == 6'd0) |-> rsp_rights_o != 3'd0); // R6
  AST_FETCH_NO_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd2) |=> rsp_rights_o[1:0] == 2'd0); // R7
  AST_DATA_NO_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != 2'd2) |=> !rsp_rights_o[2]); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_cause_o != 6'd0 ||
                     rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0]))); // R8
  AST_REFILL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_en_i |=> ridx_q == $past(ridx_q) + WAY_W'(1)); // R9
  AST_REFILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refill_en_i |=> $stable(ridx_q)); // R9
endmodule

bind asid_ring_tlb asid_tlb_checker #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .WAY_W(WAY_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .req_kind_i  (req_kind_i),
  .refill_en_i (refill_en_i),
  .ridx_q      (ridx_q),
  .rsp_valid_o (rsp_valid_o),
  .rsp_cause_o (rsp_cause_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_rights_o(rsp_rights_o)
);

// File: tb/asid_ring_tlb_tb.sv
module asid_ring_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rasid_we = 0;
  logic [31:0] rasid_d = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_way = '0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic        rf_en = 0;
  logic [19:0] rf_vpn = '0;
  logic [31:0] rf_pte = '0;
  logic [31:0] ptbase = '0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0, req_priv = '0;
  logic        rsp_valid;
  logic [5:0]  rsp_cause;
  logic [31:0] rsp_paddr, pte_addr;
  logic [2:0]  rsp_rights;
  logic [1:0]  rsp_cache, rsp_ring;

  int n_vec = 0, n_err = 0;

  always #2 clk = ~clk;

  asid_ring_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rasid_we_i(rasid_we), .rasid_i(rasid_d),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_vpn_i(wr_vpn), .wr_ppn_i(wr_ppn),
    .wr_asid_i(wr_asid), .wr_attr_i(wr_attr),
    .refill_en_i(rf_en), .refill_vpn_i(rf_vpn), .refill_pte_i(rf_pte),
    .ptbase_i(ptbase),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_kind_i(req_kind),
    .req_priv_i(req_priv),
    .rsp_valid_o(rsp_valid), .rsp_cause_o(rsp_cause), .rsp_paddr_o(rsp_paddr),
    .rsp_rights_o(rsp_rights), .rsp_cache_o(rsp_cache), .rsp_ring_o(rsp_ring),
    .pte_addr_o(pte_addr)
  );

  // reference model state
  logic [19:0] m_vpn  [4][4];
  logic [19:0] m_ppn  [4][4];
  logic [7:0]  m_asid [4][4];
  logic [3:0]  m_attr [4][4];
  logic [31:0] m_rasid = 32'h04030201;
  logic [1:0]  m_ridx = '0;

  initial begin
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++) begin
        m_vpn[w][e] = '0; m_ppn[w][e] = '0; m_asid[w][e] = '0; m_attr[w][e] = '0;
      end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic calc(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] pr,
                      output logic [5:0] c, output logic [31:0] pa, output logic [2:0] rt,
                      output logic [1:0] ca, output logic [1:0] rg);
    int idx = int'(va[13:12]);
    int hits = 0;
    int sr = 0;
    logic [19:0] sp = '0;
    int sa = 0;
    bit fe = (kind == 2'd2), st = (kind == 2'd1);
    for (int w = 0; w < 4; w++) begin
      if (m_vpn[w][idx] == va[31:12] && m_asid[w][idx] != 0) begin
        int r = -1;
        for (int b = 3; b >= 0; b--) if (m_rasid[b*8 +: 8] == m_asid[w][idx]) r = b;
        if (r >= 0) begin hits++; sr = r; sp = m_ppn[w][idx]; sa = int'(m_attr[w][idx]); end
      end
    end
    c = 0; pa = 0; rt = 0; ca = 0; rg = 2'(sr);
    if (hits == 0) c = fe ? 6'd16 : 6'd24;
    else if (hits > 1) c = fe ? 6'd17 : 6'd25;
    else if (sr < int'(pr)) c = fe ? 6'd18 : 6'd26;
    else begin
      bit r_ = (sa < 12) || (sa == 13);
      bit w_ = ((sa < 12) && (sa % 4 >= 2)) || (sa == 13);
      bit x_ = (sa < 12) && (sa % 2 == 1);
      int cc = (sa < 12) ? sa / 4 : ((sa == 13) ? 3 : 0);
      bit g;
      if (fe) begin r_ = 0; w_ = 0; end else x_ = 0;
      g = fe ? x_ : (st ? w_ : r_);
      if (!g) c = fe ? 6'd20 : (st ? 6'd29 : 6'd28);
      else begin pa = {sp, va[11:0]}; rt = {x_, w_, r_}; ca = 2'(cc); end
    end
  endtask

  task automatic compare(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] pr,
                         input string ovr);
    logic [5:0] c; logic [31:0] pa; logic [2:0] rt; logic [1:0] ca, rg;
    string tg;
    calc(va, kind, pr, c, pa, rt, ca, rg);
    if (ovr != "") tg = ovr;
    else if (c == 16 || c == 24) tg = "R3";
    else if (c == 17 || c == 25) tg = "R2";
    else if (c == 18 || c == 26) tg = "R5";
    else if (c != 0) tg = "R7";
    else tg = "R8";
    chk(rsp_valid === 1'b1, "R11", "valid", 32'(rsp_valid), 1);
    chk(rsp_cause === c, tg, "cause", 32'(rsp_cause), 32'(c));
    chk(rsp_paddr === pa, tg, "paddr", rsp_paddr, pa);
    chk(rsp_rights === rt, (c == 0 && ovr == "") ? "R6" : tg, "rights", 32'(rsp_rights), 32'(rt));
    chk(rsp_cache === ca, (c == 0 && ovr == "") ? "R6" : tg, "cache", 32'(rsp_cache), 32'(ca));
    if (c == 0) chk(rsp_ring === rg, (ovr == "") ? "R1" : ovr, "ring", 32'(rsp_ring), 32'(rg));
    chk(pte_addr === ((ptbase | (va >> 10)) & ~32'h3), "R10", "pte_addr", pte_addr,
        (ptbase | (va >> 10)) & ~32'h3);
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] pr,
                      input string ovr);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_kind = kind; req_priv = pr;
    @(negedge clk);
    req_valid = 0;
    compare(va, kind, pr, ovr);
  endtask

  task automatic wr(input int w, input logic [19:0] vpn, input logic [19:0] ppn,
                    input logic [7:0] asid, input logic [3:0] attr);
    @(negedge clk);
    wr_en = 1; wr_way = 2'(w); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
    @(negedge clk);
    wr_en = 0;
    m_vpn[w][vpn[1:0]] = vpn; m_ppn[w][vpn[1:0]] = ppn;
    m_asid[w][vpn[1:0]] = asid; m_attr[w][vpn[1:0]] = attr;
  endtask

  task automatic model_refill(input logic [19:0] vpn, input logic [31:0] pte);
    int w;
    m_ridx = m_ridx + 2'd1;
    w = int'(m_ridx);
    m_vpn[w][vpn[1:0]] = vpn; m_ppn[w][vpn[1:0]] = pte[31:12];
    m_asid[w][vpn[1:0]] = m_rasid[pte[5:4]*8 +: 8]; m_attr[w][vpn[1:0]] = pte[3:0];
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [31:0] pte);
    @(negedge clk);
    rf_en = 1; rf_vpn = vpn; rf_pte = pte;
    @(negedge clk);
    rf_en = 0;
    model_refill(vpn, pte);
  endtask

  task automatic set_rasid(input logic [31:0] v);
    @(negedge clk);
    rasid_we = 1; rasid_d = v;
    @(negedge clk);
    rasid_we = 0;
    m_rasid = v;
  endtask

  task automatic clear_all();
    for (int w = 0; w < 4; w++)
      for (int e = 0; e < 4; e++) wr(w, 20'(e), '0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R4", "valid after reset", 32'(rsp_valid), 0);
    look(32'h0000_0123, 2'd0, 2'd0, "R4");
    look(32'hFFFF_F000, 2'd2, 2'd0, "R4");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R11", "valid idle", 32'(rsp_valid), 0);

    // default ring map: tag 4 sits in byte 3
    wr(1, 20'h00777, 20'h12345, 8'd4, 4'd4);
    look(32'h0077_7ABC, 2'd0, 2'd3, "R4");
    look(32'h0077_7ABC, 2'd0, 2'd0, "R12");
    wr(1, 20'h00777, 20'h0, 8'd0, 4'd0);

    // attribute x ring x kind x privilege sweep
    ptbase = 32'hC000_0000;
    for (int a = 0; a < 16; a++)
      for (int t = 1; t <= 4; t++) begin
        wr(0, 20'hABCDE, 20'h5A5A5 ^ 20'(a * 16 + t), 8'(t), 4'(a));
        for (int k = 0; k < 4; k++)
          for (int p = 0; p < 4; p++)
            look({20'hABCDE, 12'(a * 64 + k * 16 + p * 4 + t)}, 2'(k), 2'(p), "");
      end
    wr(0, 20'hABCDE, '0, '0, '0);

    // multiple hits, unknown tag, zero tag
    wr(0, 20'h11111, 20'h22222, 8'd1, 4'd7);
    wr(3, 20'h11111, 20'h33333, 8'd2, 4'd7);
    look(32'h1111_1004, 2'd0, 2'd0, "R2");
    look(32'h1111_1008, 2'd2, 2'd0, "R2");
    wr(3, 20'h11111, 20'h33333, 8'd9, 4'd7);
    look(32'h1111_100C, 2'd1, 2'd0, "R3");
    wr(0, 20'h11111, 20'h22222, 8'd0, 4'd7);
    look(32'h1111_1010, 2'd2, 2'd0, "R3");

    // duplicate tags in the ring map: lowest byte wins
    set_rasid(32'h0707_0707);
    wr(2, 20'h44444, 20'h55555, 8'd7, 4'd3);
    look(32'h4444_4FFF, 2'd0, 2'd0, "R1");
    set_rasid(32'h0905_0905);
    look(32'h4444_4FF0, 2'd0, 2'd0, "R3");
    wr(2, 20'h44444, 20'h55555, 8'd9, 4'd3);
    look(32'h4444_4FF0, 2'd0, 2'd1, "R1");
    look(32'h4444_4FF0, 2'd0, 2'd2, "R5");
    set_rasid(32'h0403_0201);

    // refill round-robin order
    clear_all();
    refill(20'h60001, 32'hAAAA_1000 | 32'h24);
    refill(20'h60001, 32'hBBBB_2000 | 32'h24);
    look(32'h6000_1100, 2'd0, 2'd0, "R9");
    refill(20'h60001, 32'hCCCC_3000 | 32'h24);
    refill(20'h60001, 32'hDDDD_4000 | 32'h27);
    wr(1, 20'h60001, '0, '0, '0);
    wr(2, 20'h60001, '0, '0, '0);
    wr(3, 20'h60001, '0, '0, '0);
    look(32'h6000_1234, 2'd2, 2'd2, "R9");
    look(32'h6000_1234, 2'd0, 2'd3, "R9");

    // refill and lookup in one cycle; refill beats direct write on one way
    @(negedge clk);
    rf_en = 1; rf_vpn = 20'h70002; rf_pte = 32'h9999_9014;
    req_valid = 1; req_vaddr = 32'h7000_2040; req_kind = 2'd0; req_priv = 2'd0;
    @(negedge clk);
    rf_en = 0; req_valid = 0;
    compare(32'h7000_2040, 2'd0, 2'd0, "R11");
    model_refill(20'h70002, 32'h9999_9014);
    look(32'h7000_2044, 2'd0, 2'd1, "R11");
    @(negedge clk);
    rf_en = 1; rf_vpn = 20'h70003; rf_pte = 32'h8888_8004;
    wr_en = 1; wr_way = m_ridx + 2'd1; wr_vpn = 20'h70003; wr_ppn = 20'h12121;
    wr_asid = 8'd1; wr_attr = 4'd1;
    @(negedge clk);
    rf_en = 0; wr_en = 0;
    model_refill(20'h70003, 32'h8888_8004);
    look(32'h7000_3008, 2'd0, 2'd0, "R12");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int op;
      seed = seed * 32'd1664525 + 32'd1013904223;
      op = int'(seed[31:28]);
      if (op < 3)
        wr(int'(seed[5:4]), 20'h40000 + 20'(seed[12:8]), 20'(seed[27:14]),
           8'(seed[3:1]), 4'(seed[19:16]));
      else if (op < 5)
        refill(20'h40000 + 20'(seed[12:8]), {seed[27:8], 6'(seed[7:4] ^ seed[3:0]), seed[17:14]});
      else if (op == 5)
        set_rasid({5'd0, seed[2:0], 5'd0, seed[5:3], 5'd0, seed[8:6], 5'd0, seed[11:9]});
      else begin
        ptbase = {seed[15:0], 16'h0};
        look({20'h40000 + 20'(seed[12:8]), seed[27:16]}, 2'(seed[1:0]), 2'(seed[3:2]), "");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule